// File: doc/BRIEF.md
# Serial Time-Constant Baud Generator

This block produces the bit-rate timing for a serial controller from a single reference clock. A down-counter reloaded from a 16-bit time constant TC toggles a square-wave baud clock. Each half-period lasts TC+2 reference cycles, so the baud clock runs at f_ref / (2·(TC+2)). Only integer divisions of the reference can be reached, and the largest constant, 65535, sets the slowest rate.

A clock-mode stage follows the divider. In divide-by-16 mode a 4-bit prescaler counts baud-clock rising edges. It emits a mid-bit sample strobe on the eighth edge and a bit tick on the sixteenth, so the receiver can sample near the centre of each bit. In divide-by-1 mode both strobes fire on every baud rising edge. This mode gives sixteen times finer rate resolution but no mid-bit sampling point. Software sets the time constant and the mode through a small write port, and a global enable starts and stops the generator.

Top module: `tc_baud_gen`

## Requirements
- R1: While reset is asserted, and directly after it, the baud clock, the sample strobe and the bit tick are all low. The time constant resets to 0 and the mode resets to divide-by-16.
- R2: With the generator enabled, the baud clock has a period of exactly 2·(TC+2) reference cycles.
- R3: The baud clock is a 50% duty square wave. Each high phase and each low phase lasts TC+2 reference cycles.
- R4: The full 16-bit range of TC works. TC=65535 gives half-periods of 65537 cycles with no counter wrap.
- R5: A write to the time constant does not change the half-period in progress. The new value takes effect from the next counter reload.
- R6: While the enable is low, the counter holds its reload value and all three outputs are low. After the enable rises, the first baud rising edge comes TC+2 cycles later.
- R7: In divide-by-16 mode, the bit tick is one cycle wide and coincides with every sixteenth baud rising edge. The first tick after enabling falls on the sixteenth edge, so ticks are 32·(TC+2) cycles apart.
- R8: In divide-by-16 mode, the sample strobe is one cycle wide on the eighth baud rising edge of each bit. That is 16·(TC+2) cycles before the bit's tick, and never in the same cycle as the tick.
- R9: In divide-by-1 mode, the sample strobe and the bit tick both pulse for one cycle, in the first cycle that the baud clock is high.
- R10: A write with wr_sel_i=0 loads wr_data_i[15:0] as TC. A write with wr_sel_i=1 sets the mode from wr_data_i[0] (1 = divide-by-16, 0 = divide-by-1) and ignores the other data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 time constant, 1 clock mode |
| wr_data_i | input | 16 | Write data |
| enable_i | input | 1 | Generator enable |
| baud_clk_o | output | 1 | Square-wave baud clock |
| sample_o | output | 1 | Mid-bit sample strobe |
| tick_o | output | 1 | Bit-rate tick |

## Verification
The bench measures half-periods and periods at TC values of 0, 2 and 6 and at 65535. A reload off by one, or a counter that is too narrow and wraps at the top of the range, would show up as a wrong cycle count. It rewrites TC partway through a high phase and expects the current phase to finish at the old length. A design that loads the constant straight into the counter would cut that phase short. In divide-by-16 mode it times the first sample and tick against the enable edge. A prescaler that starts at the wrong count, or decodes the mid point wrongly, would move the strobe away from the bit centre. The divide-by-1 test writes a mode word whose upper bits are all set, which catches a decode that looks at the wrong data bit.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic {
    MODE_X1  = 1'b0,
    MODE_X16 = 1'b1
  } clk_mode_e;

  localparam logic SEL_TC   = 1'b0;
  localparam logic SEL_MODE = 1'b1;
endpackage

// File: rtl/brg_rst_sync.sv
module brg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/brg_cfg_regs.sv
module brg_cfg_regs
  import brg_pkg::*;
#(
  parameter int TC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [TC_W-1:0] wr_data_i,
  output logic [TC_W-1:0] tc_o,
  output clk_mode_e       mode_o
);
  logic [TC_W-1:0] tc_q, tc_d;
  clk_mode_e       mode_q, mode_d;
  logic            tc_we, mode_we;

  assign tc_we   = wr_en_i && (wr_sel_i == SEL_TC);
  assign mode_we = wr_en_i && (wr_sel_i == SEL_MODE);

  always_comb begin
    tc_d   = tc_q;
    mode_d = mode_q;
    if (tc_we)   tc_d   = wr_data_i;
    if (mode_we) mode_d = clk_mode_e'(wr_data_i[0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q   <= '0;
      mode_q <= MODE_X16;
    end else begin
      if (tc_we)   tc_q   <= tc_d;
      if (mode_we) mode_q <= mode_d;
    end
  end

  assign tc_o   = tc_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int TC_W = 16,
  localparam int CNT_W = TC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [TC_W-1:0]  tc_i,
  output logic             baud_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, reload;
  logic             baud_q, baud_d;
  logic             at_zero;

  // Half-period of TC+2 cycles: count TC+1 down to 0, then toggle and reload.
  assign reload  = {1'b0, tc_i} + CNT_W'(1);
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    baud_d = baud_q;
    if (!enable_i) begin
      cnt_d  = reload;
      baud_d = 1'b0;
    end else if (at_zero) begin
      cnt_d  = reload;
      baud_d = ~baud_q;
    end else begin
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      baud_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      baud_q <= baud_d;
    end
  end

  assign rise_o = enable_i && at_zero && !baud_q;
  assign baud_o = baud_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/brg_clk_mode.sv
module brg_clk_mode
  import brg_pkg::*;
#(
  parameter int PRE_W = 4,
  localparam logic [PRE_W-1:0] PRE_MID = PRE_W'(1 << (PRE_W - 1)),
  localparam logic [PRE_W-1:0] PRE_MAX = '1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  input  logic      rise_i,
  input  clk_mode_e mode_i,
  output logic      sample_o,
  output logic      tick_o
);
  logic [PRE_W-1:0] pre_q, pre_d, pre_inc;
  logic             sample_q, sample_d;
  logic             tick_q, tick_d;

  assign pre_inc = pre_q + PRE_W'(1);

  always_comb begin
    pre_d    = pre_q;
    sample_d = 1'b0;
    tick_d   = 1'b0;
    if (!enable_i) begin
      pre_d = '0;
    end else if (rise_i) begin
      if (mode_i == MODE_X16) begin
        pre_d    = pre_inc;
        sample_d = (pre_inc == PRE_MID);
        tick_d   = (pre_q == PRE_MAX);
      end else begin
        pre_d    = '0;
        sample_d = 1'b1;
        tick_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      sample_q <= 1'b0;
      tick_q   <= 1'b0;
    end else begin
      pre_q    <= pre_d;
      sample_q <= sample_d;
      tick_q   <= tick_d;
    end
  end

  assign sample_o = sample_q;
  assign tick_o   = tick_q;
endmodule

// File: rtl/tc_baud_gen.sv
module tc_baud_gen
  import brg_pkg::*;
#(
  parameter int TC_W  = 16,
  parameter int PRE_W = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = TC_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [TC_W-1:0] wr_data_i,
  input  logic            enable_i,
  output logic            baud_clk_o,
  output logic            sample_o,
  output logic            tick_o
);
  logic             rst_n_s;
  logic [TC_W-1:0]  tc_val;
  clk_mode_e        mode_val;
  logic             baud_rise;
  logic [CNT_W-1:0] div_cnt;

  brg_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  brg_cfg_regs #(.TC_W(TC_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .tc_o      (tc_val),
    .mode_o    (mode_val)
  );

  brg_divider #(.TC_W(TC_W)) i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .enable_i (enable_i),
    .tc_i     (tc_val),
    .baud_o   (baud_clk_o),
    .rise_o   (baud_rise),
    .cnt_o    (div_cnt)
  );

  brg_clk_mode #(.PRE_W(PRE_W)) i_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .enable_i (enable_i),
    .rise_i   (baud_rise),
    .mode_i   (mode_val),
    .sample_o (sample_o),
    .tick_o   (tick_o)
  );
endmodule

// File: rtl/tc_baud_gen_chk.sv
module tc_baud_gen_chk
  import brg_pkg::*;
#(
  parameter int TC_W = 16,
  localparam int CNT_W = TC_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_n_s,
  input logic             enable_i,
  input logic [TC_W-1:0]  tc_val,
  input clk_mode_e        mode_val,
  input logic [CNT_W-1:0] div_cnt,
  input logic             baud_clk_o,
  input logic             sample_o,
  input logic             tick_o
);
  // R1: outputs low while reset is held
  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (!baud_clk_o && !sample_o && !tick_o));

  // R2: baud clock changes only at a terminal count or when disabled
  a_r2_toggle_at_zero: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (baud_clk_o != $past(baud_clk_o)) |-> (($past(div_cnt) == '0) || !$past(enable_i)));

  // R5: running counter steps down by one between reloads
  a_r5_countdown: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (enable_i && div_cnt != '0) |=> (div_cnt == $past(div_cnt) - CNT_W'(1)));

  // R6: disabled generator holds its reload value and stays quiet
  a_r6_hold_reload: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !enable_i |=> (div_cnt == ({1'b0, $past(tc_val)} + CNT_W'(1))));

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !enable_i |=> (!baud_clk_o && !sample_o && !tick_o));

  // R7: the bit tick lasts a single cycle
  a_r7_tick_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (tick_o && $past(mode_val) == MODE_X16) |=> !tick_o);

  // R8: sample strobe and tick never coincide in divide-by-16 mode
  a_r8_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ($past(mode_val) == MODE_X16) |-> !(sample_o && tick_o));

  // R9: divide-by-1 strobes accompany each baud rising edge
  a_r9_x1_strobes: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ($rose(baud_clk_o) && $past(mode_val) == MODE_X1) |-> (sample_o && tick_o));
endmodule

bind tc_baud_gen tc_baud_gen_chk #(.TC_W(TC_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_n_s    (rst_n_s),
  .enable_i   (enable_i),
  .tc_val     (tc_val),
  .mode_val   (mode_val),
  .div_cnt    (div_cnt),
  .baud_clk_o (baud_clk_o),
  .sample_o   (sample_o),
  .tick_o     (tick_o)
);

// File: tb/test_tc_baud_gen.sv
`timescale 1ns/1ps
module test_tc_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [15:0] wr_data;
  logic        en;
  logic        baud, smp, tick;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tc_baud_gen i_tc_baud_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .enable_i   (en),
    .baud_clk_o (baud),
    .sample_o   (smp),
    .tick_o     (tick)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    if (cyc == 195000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, cycle %0d expected below 195000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int idx);
    case (idx)
      0:       return baud;
      1:       return smp;
      default: return tick;
    endcase
  endfunction

  // Waits until output idx shows level lvl at a falling edge; returns the cycle stamp.
  task automatic wait_sig(input int idx, input logic lvl, output int t);
    t = -1;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (sig(idx) == lvl) begin
        t = cyc;
        return;
      end
    end
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic start_gen(input logic [15:0] tc, input logic [15:0] mode_word, output int t0);
    @(negedge clk); en = 1'b0;
    write_reg(1'b1, mode_word);
    write_reg(1'b0, tc);
    @(negedge clk);
    en = 1'b1;
    t0 = cyc;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 baud in reset", baud, 0);
    check("R1 sample in reset", smp, 0);
    check("R1 tick in reset", tick, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 outputs after reset", {baud, smp, tick}, 0);
  endtask

  task automatic t_period(input int tc);
    int t0, tr, tf, tr2;
    start_gen(16'(tc), 16'h0000, t0);
    wait_sig(0, 1'b1, tr);
    check($sformatf("R6 first rise latency tc=%0d", tc), tr - t0, tc + 2);
    wait_sig(0, 1'b0, tf);
    check($sformatf("R3 high phase tc=%0d", tc), tf - tr, tc + 2);
    wait_sig(0, 1'b1, tr2);
    check($sformatf("R3 low phase tc=%0d", tc), tr2 - tf, tc + 2);
    check($sformatf("R2 period tc=%0d", tc), tr2 - tr, 2 * (tc + 2));
  endtask

  task automatic t_x1_strobes();
    int t0, tr;
    // R10: mode word with upper bits set and bit 0 clear selects divide-by-1
    start_gen(16'd2, 16'hFFFE, t0);
    for (int k = 0; k < 3; k++) begin
      wait_sig(0, 1'b1, tr);
      check("R9 sample with baud rise", smp, 1);
      check("R9 tick with baud rise", tick, 1);
      @(negedge clk);
      check("R9 strobes one cycle", {smp, tick}, 0);
      wait_sig(0, 1'b0, tr);
    end
  endtask

  task automatic t_disable();
    int seen = 0;
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (baud || smp || tick) seen++;
    end
    check("R6 outputs quiet while disabled", seen, 0);
  endtask

  task automatic t_tc_change();
    int t0, tr, tf, tr2, tf2;
    start_gen(16'd10, 16'h0000, t0);
    wait_sig(0, 1'b1, tr);
    @(negedge clk);
    write_reg(1'b0, 16'd3);
    wait_sig(0, 1'b0, tf);
    check("R5 phase in progress keeps old TC", tf - tr, 12);
    wait_sig(0, 1'b1, tr2);
    check("R5 next phase uses new TC", tr2 - tf, 5);
    wait_sig(0, 1'b0, tf2);
    check("R5 new TC persists", tf2 - tr2, 5);
  endtask

  task automatic t_x16();
    int t0, ts, t1, ts2, t2;
    start_gen(16'd0, 16'h0001, t0);
    wait_sig(1, 1'b1, ts);
    check("R8 first sample on 8th rise", ts - t0, 15 * 2);
    check("R8 sample without tick", tick, 0);
    wait_sig(2, 1'b1, t1);
    check("R7 first tick on 16th rise", t1 - t0, 31 * 2);
    check("R8 tick without sample", smp, 0);
    @(negedge clk);
    check("R7 tick one cycle wide", tick, 0);
    wait_sig(1, 1'b1, ts2);
    wait_sig(2, 1'b1, t2);
    check("R7 tick spacing", t2 - t1, 32 * 2);
    check("R8 sample half a bit before tick", t2 - ts2, 16 * 2);
  endtask

  task automatic t_max();
    int t0, tr, tf;
    start_gen(16'hFFFF, 16'h0000, t0);
    wait_sig(0, 1'b1, tr);
    check("R4 max TC first half-period", tr - t0, 65537);
    wait_sig(0, 1'b0, tf);
    check("R4 max TC high phase", tf - tr, 65537);
    @(negedge clk); en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; en = 1'b0;
    t_reset();
    t_period(0);
    t_period(2);
    t_period(6);
    t_x1_strobes();
    t_disable();
    t_tc_change();
    t_x16();
    t_disable();
    t_max();
    summary();
    $finish;
  end
endmodule